// File: doc/BRIEF.md
# Locked Revolution and 360-Step Pulse Generator

This block imitates the signals of a rotating shaft. It drives a once-per-revolution index pulse (`rev_out`) and a step train (`step_out`) that has a fixed number of pulses per revolution. The default is 360 pulses. Both outputs count their high and low phases in ticks of one shared timebase. The timebase is a programmable divider of the system clock, with separate high and low clock counts.

The host writes the divider counts at any time. A new setting is held until the current timebase period completes, and it then becomes the live setting. Changing the divider therefore changes the simulated rotation speed, and both outputs follow together with no restart. The revolution and step counts are captured when generation starts. The step train is launched once, at the first falling edge of the revolution pulse. From then on it runs freely. Because it has the same tick source, every revolution falling edge coincides with a step falling edge.

Before a start is accepted, the block checks that every count is non-zero and that the revolution period is exactly the pulse count times the step period. If either check fails, the start is refused and an error flag is raised.

Top module: `shaft_pulse_gen`

## Requirements
- R1: While `rst_n` is low, `rev_out`, `step_out`, `tick_stb` and `cfg_err` are all 0. They remain 0 after reset until a start is accepted.
- R2: While running, `tick_stb` is high for exactly one clock. It repeats every `tb_hi_clks + tb_lo_clks` clocks of the live divider setting.
- R3: A divider setting written during a run is applied only when a full timebase period ends. Each tick interval uses the old setting or the new one, never a mix of the two.
- R4: A divider setting in which either count is zero is never loaded. The previous live setting stays in force.
- R5: An accepted start drives `rev_out` high in the next clock. It then stays high for `rev_hi_ticks` ticks and low for `rev_lo_ticks` ticks, and repeats.
- R6: `step_out` stays low until the first falling edge of `rev_out`. From that tick on, it alternates `step_lo_ticks` ticks low and then `step_hi_ticks` ticks high. It changes only in the clock after a tick.
- R7: Each revolution period contains exactly PULSES falling edges of `step_out`. The last of them falls in the same clock as `rev_out` falls. This still holds after the divider has been changed.
- R8: A start is refused when any of the six counts is zero, or when `rev_hi_ticks + rev_lo_ticks` is not PULSES times `step_hi_ticks + step_lo_ticks`. In that case `cfg_err` is 1 one clock later and `rev_out` stays low. An accepted start clears `cfg_err`.
- R9: When `enable` is low, generation stops. All of `rev_out`, `step_out` and `tick_stb` read 0 one clock later, and `start` has no effect.
- R10: The revolution and step counts are captured at the accepted start. Changing them during a run does not alter either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows generation; low stops it |
| start | input | 1 | Request to begin generation |
| tb_hi_clks | input | CW | Timebase high phase in system clocks |
| tb_lo_clks | input | CW | Timebase low phase in system clocks |
| rev_hi_ticks | input | CW | Revolution pulse high phase in ticks |
| rev_lo_ticks | input | CW | Revolution pulse low phase in ticks |
| step_hi_ticks | input | CW | Step pulse high phase in ticks |
| step_lo_ticks | input | CW | Step pulse low phase in ticks |
| rev_out | output | 1 | Once-per-revolution pulse |
| step_out | output | 1 | Step train, PULSES per revolution |
| tick_stb | output | 1 | One-clock timebase strobe |
| cfg_err | output | 1 | Last start was refused |

## Verification
On one tick, the revolution counter ends its high phase and the step counter ends a high phase, so both outputs fall in the same clock. The bench provokes this coincidence at every revolution, both before and after a speed change. It judges it by detecting both falls in the same sampled clock, and by counting exactly PULSES step falls between two revolution falls. The divider reload can also land on the tick that moves both counters. That case is provoked by rewriting the divider in mid-revolution. It is judged by tick intervals that take only the old or the new length, and by a revolution period of exactly the new length.

// File: rtl/shaft_pkg.sv
package shaft_pkg;
  typedef enum logic {PH_LO = 1'b0, PH_HI = 1'b1} phase_e;

  function automatic phase_e flip(phase_e p);
    return (p == PH_HI) ? PH_LO : PH_HI;
  endfunction
endpackage

// File: rtl/tick_divider.sv
module tick_divider
  import shaft_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] hi_req,
  input  logic [CW-1:0] lo_req,
  output logic          tick
);
  logic [CW-1:0] live_hi_q, live_hi_d;
  logic [CW-1:0] live_lo_q, live_lo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  phase_e        ph_q, ph_d;
  logic          req_ok, phase_end;

  assign req_ok    = (hi_req != '0) && (lo_req != '0);
  assign phase_end = (cnt_q == (((ph_q == PH_HI) ? live_hi_q : live_lo_q) - CW'(1)));
  assign tick      = run && (ph_q == PH_LO) && phase_end;

  always_comb begin
    live_hi_d = live_hi_q;
    live_lo_d = live_lo_q;
    cnt_d     = cnt_q;
    ph_d      = ph_q;
    if (!run) begin
      cnt_d = '0;
      ph_d  = PH_HI;
      if (req_ok) begin
        live_hi_d = hi_req;
        live_lo_d = lo_req;
      end
    end else if (phase_end) begin
      cnt_d = '0;
      ph_d  = flip(ph_q);
      if ((ph_q == PH_LO) && req_ok) begin
        live_hi_d = hi_req;
        live_lo_d = lo_req;
      end
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_hi_q <= CW'(1);
      live_lo_q <= CW'(1);
      cnt_q     <= '0;
      ph_q      <= PH_HI;
    end else begin
      live_hi_q <= live_hi_d;
      live_lo_q <= live_lo_d;
      cnt_q     <= cnt_d;
      ph_q      <= ph_d;
    end
  end
endmodule

// File: rtl/phase_gen.sv
module phase_gen
  import shaft_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          launch,
  input  phase_e        launch_ph,
  input  logic          tick,
  input  logic [CW-1:0] hi_cnt,
  input  logic [CW-1:0] lo_cnt,
  output logic          active,
  output logic          out,
  output logic          fall
);
  logic          act_q, act_d;
  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_end;

  assign phase_end = (cnt_q == (((ph_q == PH_HI) ? hi_cnt : lo_cnt) - CW'(1)));
  assign active    = act_q;
  assign out       = act_q && (ph_q == PH_HI);
  assign fall      = act_q && tick && (ph_q == PH_HI) && phase_end;

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (clr) begin
      act_d = 1'b0;
      ph_d  = PH_LO;
      cnt_d = '0;
    end else if (launch) begin
      act_d = 1'b1;
      ph_d  = launch_ph;
      cnt_d = '0;
    end else if (act_q && tick) begin
      if (phase_end) begin
        ph_d  = flip(ph_q);
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= PH_LO;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/shaft_pulse_gen.sv
module shaft_pulse_gen
  import shaft_pkg::*;
#(
  parameter int CW     = 32,
  parameter int PULSES = 360
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          start,
  input  logic [CW-1:0] tb_hi_clks,
  input  logic [CW-1:0] tb_lo_clks,
  input  logic [CW-1:0] rev_hi_ticks,
  input  logic [CW-1:0] rev_lo_ticks,
  input  logic [CW-1:0] step_hi_ticks,
  input  logic [CW-1:0] step_lo_ticks,
  output logic          rev_out,
  output logic          step_out,
  output logic          tick_stb,
  output logic          cfg_err
);
  localparam int PW = CW + 2 + $clog2(PULSES + 1);

  logic          run_q, run_d;
  logic          err_q, err_d;
  logic [CW-1:0] rh_q, rl_q, sh_q, sl_q;
  logic [PW-1:0] rev_sum, step_scaled;
  logic          nonzero, cfg_ok, try_start, accept;
  logic          tick, rev_fall, rev_act, step_act, step_fall_unused;

  assign nonzero = (tb_hi_clks != '0) && (tb_lo_clks != '0) &&
                   (rev_hi_ticks != '0) && (rev_lo_ticks != '0) &&
                   (step_hi_ticks != '0) && (step_lo_ticks != '0);
  assign rev_sum     = PW'(rev_hi_ticks) + PW'(rev_lo_ticks);
  assign step_scaled = (PW'(step_hi_ticks) + PW'(step_lo_ticks)) * PW'(PULSES);
  assign cfg_ok      = nonzero && (rev_sum == step_scaled);
  assign try_start   = enable && start && !run_q;
  assign accept      = try_start && cfg_ok;

  always_comb begin
    run_d = enable && (run_q || accept);
    err_d = try_start ? !cfg_ok : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      err_q <= 1'b0;
      rh_q  <= '0;
      rl_q  <= '0;
      sh_q  <= '0;
      sl_q  <= '0;
    end else begin
      run_q <= run_d;
      err_q <= err_d;
      if (accept) begin
        rh_q <= rev_hi_ticks;
        rl_q <= rev_lo_ticks;
        sh_q <= step_hi_ticks;
        sl_q <= step_lo_ticks;
      end
    end
  end

  tick_divider #(.CW(CW)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .hi_req (tb_hi_clks),
    .lo_req (tb_lo_clks),
    .tick   (tick)
  );

  phase_gen #(.CW(CW)) u_rev (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!enable),
    .launch    (accept),
    .launch_ph (PH_HI),
    .tick      (tick),
    .hi_cnt    (rh_q),
    .lo_cnt    (rl_q),
    .active    (rev_act),
    .out       (rev_out),
    .fall      (rev_fall)
  );

  phase_gen #(.CW(CW)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!enable),
    .launch    (rev_fall && !step_act),
    .launch_ph (PH_LO),
    .tick      (tick),
    .hi_cnt    (sh_q),
    .lo_cnt    (sl_q),
    .active    (step_act),
    .out       (step_out),
    .fall      (step_fall_unused)
  );

  assign tick_stb = tick;
  assign cfg_err  = err_q;
endmodule

// File: rtl/shaft_pulse_gen_chk.sv
module shaft_pulse_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic rev_out,
  input logic step_out,
  input logic tick_stb,
  input logic cfg_err
);
  // R2: the strobe never lasts two clocks
  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_stb |=> !tick_stb);

  // R9: a low enable silences every output one clock later
  a_r9_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!rev_out && !step_out && !tick_stb));

  // R8: a refused start leaves the revolution pulse low
  a_r8_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> !rev_out);

  // R6: the step output rises only after a tick
  a_r6_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_out) |-> $past(tick_stb));

  // R7: after a revolution fall the step output is low as well
  a_r7_fall_together: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rev_out) && enable) |-> !step_out);

  // R1: reset state
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_low: assert (!tick_stb);
    end
  end
endmodule

bind shaft_pulse_gen shaft_pulse_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .rev_out  (rev_out),
  .step_out (step_out),
  .tick_stb (tick_stb),
  .cfg_err  (cfg_err)
);

// File: tb/shaft_pulse_gen_tb.sv
module shaft_pulse_gen_tb;
  localparam int CW = 32;
  localparam int NV = 7;

  logic clk = 1'b0;
  logic rst_n, enable, start;
  logic [CW-1:0] tbh, tbl, rh, rl, sh, sl;
  logic rev_out, step_out, tick_stb, cfg_err;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  shaft_pulse_gen #(.CW(CW), .PULSES(360)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
    .tb_hi_clks(tbh), .tb_lo_clks(tbl),
    .rev_hi_ticks(rh), .rev_lo_ticks(rl),
    .step_hi_ticks(sh), .step_lo_ticks(sl),
    .rev_out(rev_out), .step_out(step_out), .tick_stb(tick_stb), .cfg_err(cfg_err)
  );

  // config vectors: rev hi/lo, step hi/lo, timebase hi/lo, expected error
  localparam int V_RH[NV]  = '{360, 700, 360,   0, 360, 540, 360};
  localparam int V_RL[NV]  = '{360,  20, 359, 720, 360, 540, 360};
  localparam int V_SH[NV]  = '{  1,   1,   1,   1,   0,   2,   1};
  localparam int V_SL[NV]  = '{  1,   1,   1,   1,   2,   1,   1};
  localparam int V_TH[NV]  = '{  2,   2,   2,   2,   2,   2,   0};
  localparam int V_TL[NV]  = '{  1,   1,   1,   1,   1,   1,   3};
  localparam bit V_ERR[NV] = '{  0,   0,   1,   1,   1,   0,   1};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic tick_gap(output int gap);
    gap = 0;
    while (!tick_stb) @(negedge clk);
    @(negedge clk);
    gap = 1;
    while (!tick_stb) begin
      @(negedge clk);
      gap++;
    end
  endtask

  task automatic measure_rev(output int hi, output int per, output int sf, output bit al);
    bit pm, ps;
    pm = rev_out;
    forever begin
      @(negedge clk);
      if (pm && !rev_out) break;
      pm = rev_out;
    end
    hi = 0; per = 0; sf = 0; al = 0;
    pm = 1'b0;
    ps = step_out;
    forever begin
      @(negedge clk);
      per++;
      if (rev_out) hi++;
      if (ps && !step_out) sf++;
      if (pm && !rev_out) begin
        al = ps && !step_out;
        break;
      end
      pm = rev_out;
      ps = step_out;
    end
  endtask

  task automatic set_cfg(input int i);
    rh = V_RH[i]; rl = V_RL[i]; sh = V_SH[i]; sl = V_SL[i];
    tbh = V_TH[i]; tbl = V_TL[i];
  endtask

  initial begin
    int hi, per, sf, gap;
    bit al, only_ok;
    rst_n = 1'b0; enable = 1'b0; start = 1'b0;
    set_cfg(0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!rev_out && !step_out && !tick_stb && !cfg_err, "R1 reset outputs",
        {rev_out, step_out, tick_stb, cfg_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rev_out && !step_out && !cfg_err, "R1 idle after reset", {rev_out, step_out, cfg_err}, 0);

    // R8 / R5: table of configurations
    for (int i = 0; i < NV; i++) begin
      set_cfg(i);
      enable = 1'b1;
      pulse_start();
      chk(cfg_err == V_ERR[i], "R8 cfg_err per vector", cfg_err, V_ERR[i]);
      chk(rev_out == !V_ERR[i], "R5 rev high after start", rev_out, !V_ERR[i]);
      @(negedge clk) enable = 1'b0;
      @(negedge clk);
      chk(!rev_out && !step_out && !tick_stb, "R9 stop on disable", {rev_out, step_out, tick_stb}, 0);
    end

    // R9: start with enable low does nothing
    set_cfg(0);
    pulse_start();
    repeat (3) @(negedge clk);
    chk(!rev_out && !tick_stb, "R9 start ignored when disabled", {rev_out, tick_stb}, 0);

    // main run at 3 clocks per tick
    enable = 1'b1;
    pulse_start();
    chk(!cfg_err, "R8 cleared by good start", cfg_err, 0);
    chk(!step_out, "R6 step idle before first fall", step_out, 0);
    tick_gap(gap);
    chk(gap == 3, "R2 tick interval", gap, 3);
    measure_rev(hi, per, sf, al);
    chk(hi == 1080, "R5 rev high clocks", hi, 1080);
    chk(per == 2160, "R5 rev period clocks", per, 2160);
    chk(sf == 360, "R7 step falls per rev", sf, 360);
    chk(al, "R7 falls coincide", al, 1);

    // R3: speed change in mid-revolution
    repeat (400) @(negedge clk);
    tbh = 3; tbl = 2;
    only_ok = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick_gap(gap);
      if (gap != 3 && gap != 5) only_ok = 1'b0;
    end
    chk(only_ok, "R3 only old or new interval", only_ok, 1);
    chk(gap == 5, "R3 new interval in force", gap, 5);
    measure_rev(hi, per, sf, al);
    chk(per == 3600, "R7 period after speed change", per, 3600);
    chk(sf == 360, "R7 step falls after speed change", sf, 360);
    chk(al, "R7 coincide after speed change", al, 1);

    // R4: zero divider count is not loaded
    tbh = 0;
    for (int k = 0; k < 3; k++) begin
      tick_gap(gap);
      chk(gap == 5, "R4 zero count ignored", gap, 5);
    end
    tbh = 3;

    // R10: pulse settings changed during run are ignored
    rh = 100; rl = 50; sh = 7; sl = 9;
    measure_rev(hi, per, sf, al);
    chk(hi == 1800 && per == 3600, "R10 rev timing kept", per, 3600);
    chk(sf == 360, "R10 step count kept", sf, 360);

    // R9: disable mid-run
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    chk(!rev_out && !step_out && !tick_stb, "R9 disable mid-run", {rev_out, step_out, tick_stb}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule